// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides, in a single combinational pass, whether one physical memory access may proceed. It receives every protection entry's 8-bit configuration byte and its address register from the configuration register file. It also receives the access itself: byte address, size code, kind (load, store or instruction fetch) and privilege level. The block outputs one allow bit and its complement, a fault bit.

The entries are searched in order of index. The entry with the lowest index that touches any byte of the access decides the result. That entry must hold the whole access. If it does, the permission bit for the access kind must be set. Machine-mode accesses are checked against an entry's permissions only if that entry is locked. Entries at or above `IMPL_ENTRIES` are hardwired to zero, so their inputs have no effect. One grain parameter, shared by all entries, coarsens the regions that every entry can describe. The result feeds the trap logic of the core, which lies outside this block. The block has no clock and holds no state, so no handshake applies to it.

Top module: `pmpc_checker`

## Requirements
- R1: With `IMPL_ENTRIES` > 0, a user-mode or supervisor-mode access that overlaps no entry faults. Privilege code 2'b11 is machine mode, and every other code is non-machine.
- R2: With `IMPL_ENTRIES` = 0, every access is allowed, whatever the configuration inputs hold.
- R3: Address-mode field cfg[4:3] = 2'b01 selects the range mode. Entry i covers the words from the address register of entry i-1 (zero for entry 0) up to, but not including, its own address register. The entry is empty when that lower bound is not below the upper bound.
- R4: When several entries overlap an access, only the lowest-indexed one decides the result. Entries with higher indices have no effect.
- R5: If the deciding entry covers only part of the access, the access faults in every privilege mode. An access spans 2^size bytes, with size taken from `req_size_i`.
- R6: The access kind is coded as 0 load, 1 store, 2 fetch and 3 reserved. The load needs cfg[0], the store needs cfg[1] and the fetch needs cfg[2]. A reserved kind never passes a permission check.
- R7: A machine-mode access is allowed when it overlaps no entry. It is also allowed when the deciding entry fully covers it and that entry's lock bit cfg[7] is clear. When the lock bit is set, the entry's permissions apply.
- R8: Mode 2'b11 is the naturally aligned power-of-two mode. Here k trailing ones of the address register give a region of 2^(k+3) bytes, whose base is the register with those k ones and the next bit cleared. Mode 2'b00 and mode 2'b10 never match.
- R9: Entries with an index of `IMPL_ENTRIES` or higher never match.
- R10: With `GRAIN` = G ≥ 1, the low G bits of an address register read as zero in range mode. In power-of-two mode, the low G-1 bits read as ones. Every region is therefore at least 2^(G+2) bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_flat_i | input | 8*NUM_ENTRIES | Configuration byte of entry i at bits [8i+7:8i] |
| addr_flat_i | input | (PADDR_W-2)*NUM_ENTRIES | Address register of entry i, holding byte address bits PADDR_W-1..2 |
| req_addr_i | input | PADDR_W | Byte address of the access |
| req_size_i | input | 2 | log2 of the access length in bytes |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| req_priv_i | input | 2 | Privilege level: 3 machine, 1 supervisor, 0 user |
| allow_o | output | 1 | Access permitted |
| fault_o | output | 1 | Access denied |

## Verification
The assertions assume that the inputs settle together and are sampled only after they settle. They also assume that `IMPL_ENTRIES` does not exceed `NUM_ENTRIES`. Range and region arithmetic is trusted to be wide enough that the end of an access never wraps past the top of the address space. The stimulus keeps to these limits: it changes all request and configuration inputs in one step, well before the sampling point. It also uses only addresses whose last byte lies inside the address space. Three instances are driven: one with some hardwired entries, one with a coarse grain, and one with no entries at all.

// File: rtl/pmpc_pkg.sv
`timescale 1ns/1ps
package pmpc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_TOR   = 2'b01,
    MODE_GAP   = 2'b10,
    MODE_NAPOT = 2'b11
  } pmpc_mode_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } pmpc_kind_e;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  localparam int unsigned CFG_LOCK_BIT = 7;
  localparam int unsigned CFG_MODE_LSB = 3;
  localparam int unsigned CFG_PERM_LSB = 0;

endpackage

// File: rtl/pmpc_region.sv
`timescale 1ns/1ps
module pmpc_region
  import pmpc_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned GRAIN  = 0,
  parameter bit          ACTIVE = 1'b1
) (
  input  logic [7:0]    cfg_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] prev_i,
  output logic [AW+1:0] lo_o,
  output logic [AW+1:0] hi_o,
  output logic          valid_o,
  output logic [2:0]    perm_o,
  output logic          locked_o
);

  localparam int unsigned WW = AW + 2;

  function automatic logic [AW-1:0] ones_below(input int unsigned n);
    logic [AW-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < AW; b++) begin
      if (b < n) m[b] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [AW-1:0] CLEAR_M = ones_below(GRAIN);
  localparam logic [AW-1:0] FILL_M  = (GRAIN == 0) ? '0 : ones_below(GRAIN - 1);

  generate
    if (ACTIVE) begin : g_live
      pmpc_mode_e    mode;
      logic [WW-1:0] tor_lo, tor_hi;
      logic [WW-1:0] nap, nap_ones, nap_lo, nap_hi;
      logic          unused_spare;

      assign unused_spare = ^cfg_i[6:5];
      assign mode     = pmpc_mode_e'(cfg_i[CFG_MODE_LSB +: 2]);
      assign perm_o   = cfg_i[CFG_PERM_LSB +: 3];
      assign locked_o = cfg_i[CFG_LOCK_BIT];

      // range mode: grain clears the low bits of both bounds
      assign tor_lo = {2'b00, prev_i & ~CLEAR_M};
      assign tor_hi = {2'b00, addr_i & ~CLEAR_M};

      // power-of-two mode: grain forces the low bits to ones
      assign nap      = {2'b00, addr_i | FILL_M};
      assign nap_ones = nap ^ (nap + WW'(1));
      assign nap_lo   = nap & ~nap_ones;
      assign nap_hi   = nap_lo + nap_ones + WW'(1);

      always_comb begin
        lo_o    = '0;
        hi_o    = '0;
        valid_o = 1'b0;
        unique case (mode)
          MODE_TOR: begin
            lo_o    = tor_lo;
            hi_o    = tor_hi;
            valid_o = tor_lo < tor_hi;
          end
          MODE_NAPOT: begin
            lo_o    = nap_lo;
            hi_o    = nap_hi;
            valid_o = 1'b1;
          end
          default: valid_o = 1'b0;
        endcase
      end

      always_comb begin
        if (valid_o) begin
          a_r8_region_nonempty: assert (lo_o < hi_o)
            else $error("a_r8_region_nonempty: region bounds inverted");
        end
      end
    end else begin : g_tied
      logic unused_in;
      assign unused_in = ^{cfg_i, addr_i, prev_i};
      assign lo_o     = '0;
      assign hi_o     = '0;
      assign valid_o  = 1'b0;
      assign perm_o   = '0;
      assign locked_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pmpc_match.sv
`timescale 1ns/1ps
module pmpc_match #(
  parameter int unsigned PADDR_W = 34
) (
  input  logic [PADDR_W-1:0] lo_w_i,
  input  logic [PADDR_W-1:0] hi_w_i,
  input  logic               valid_i,
  input  logic [PADDR_W+1:0] acc_lo_i,
  input  logic [PADDR_W+1:0] acc_hi_i,
  output logic               overlap_o,
  output logic               full_o
);

  logic [PADDR_W+1:0] lo_b, hi_b;

  assign lo_b = {lo_w_i, 2'b00};
  assign hi_b = {hi_w_i, 2'b00};

  assign overlap_o = valid_i && (acc_lo_i < hi_b) && (acc_hi_i > lo_b);
  assign full_o    = valid_i && (acc_lo_i >= lo_b) && (acc_hi_i <= hi_b);

  always_comb begin
    if (full_o) begin
      a_r5_full_implies_touch: assert (overlap_o)
        else $error("a_r5_full_implies_touch: covered access not flagged as touching");
    end
  end

endmodule

// File: rtl/pmpc_priority.sv
`timescale 1ns/1ps
module pmpc_priority #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]      overlap_i,
  input  logic [N-1:0]      full_i,
  input  logic [N-1:0][2:0] perm_i,
  input  logic [N-1:0]      locked_i,
  output logic              hit_o,
  output logic              sel_full_o,
  output logic [2:0]        sel_perm_o,
  output logic              sel_locked_o
);

  logic [N-1:0] sel;

  always_comb begin
    hit_o        = 1'b0;
    sel          = '0;
    sel_full_o   = 1'b0;
    sel_perm_o   = '0;
    sel_locked_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (overlap_i[i]) begin
        hit_o        = 1'b1;
        sel          = '0;
        sel[i]       = 1'b1;
        sel_full_o   = full_i[i];
        sel_perm_o   = perm_i[i];
        sel_locked_o = locked_i[i];
      end
    end
  end

  always_comb begin
    a_r4_single_winner: assert ($onehot0(sel))
      else $error("a_r4_single_winner: more than one entry selected");
    a_r4_lowest_wins: assert (!(|(overlap_i & (sel - N'(1)))))
      else $error("a_r4_lowest_wins: a lower entry overlaps but was passed over");
  end

endmodule

// File: rtl/pmpc_checker.sv
`timescale 1ns/1ps
module pmpc_checker
  import pmpc_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES  = 16,
  parameter int unsigned IMPL_ENTRIES = 8,
  parameter int unsigned PADDR_W      = 34,
  parameter int unsigned GRAIN        = 0
) (
  input  logic [8*NUM_ENTRIES-1:0]           cfg_flat_i,
  input  logic [(PADDR_W-2)*NUM_ENTRIES-1:0] addr_flat_i,
  input  logic [PADDR_W-1:0]                 req_addr_i,
  input  logic [1:0]                         req_size_i,
  input  logic [1:0]                         req_kind_i,
  input  logic [1:0]                         req_priv_i,
  output logic                               allow_o,
  output logic                               fault_o
);

  localparam int unsigned AW = PADDR_W - 2;
  localparam int unsigned BW = PADDR_W + 2;

  logic [BW-1:0] acc_lo, acc_hi;
  assign acc_lo = BW'(req_addr_i);
  assign acc_hi = acc_lo + (BW'(1) << req_size_i);

  logic [NUM_ENTRIES-1:0]      ovl, full, lock;
  logic [NUM_ENTRIES-1:0][2:0] perm;

  generate
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      logic [AW-1:0]   prev;
      logic [PADDR_W-1:0] lo_w, hi_w;
      logic            vld;

      if (i == 0) begin : g_first
        assign prev = '0;
      end else begin : g_next
        assign prev = addr_flat_i[(i-1)*AW +: AW];
      end

      pmpc_region #(
        .AW     (AW),
        .GRAIN  (GRAIN),
        .ACTIVE (i < IMPL_ENTRIES)
      ) u_region (
        .cfg_i    (cfg_flat_i[i*8 +: 8]),
        .addr_i   (addr_flat_i[i*AW +: AW]),
        .prev_i   (prev),
        .lo_o     (lo_w),
        .hi_o     (hi_w),
        .valid_o  (vld),
        .perm_o   (perm[i]),
        .locked_o (lock[i])
      );

      pmpc_match #(
        .PADDR_W (PADDR_W)
      ) u_match (
        .lo_w_i    (lo_w),
        .hi_w_i    (hi_w),
        .valid_i   (vld),
        .acc_lo_i  (acc_lo),
        .acc_hi_i  (acc_hi),
        .overlap_o (ovl[i]),
        .full_o    (full[i])
      );
    end
  endgenerate

  logic       hit, sel_full, sel_locked;
  logic [2:0] sel_perm;

  pmpc_priority #(
    .N (NUM_ENTRIES)
  ) u_prio (
    .overlap_i    (ovl),
    .full_i       (full),
    .perm_i       (perm),
    .locked_i     (lock),
    .hit_o        (hit),
    .sel_full_o   (sel_full),
    .sel_perm_o   (sel_perm),
    .sel_locked_o (sel_locked)
  );

  logic is_m, perm_ok;
  assign is_m = (req_priv_i == PRIV_MACHINE);

  always_comb begin
    unique case (pmpc_kind_e'(req_kind_i))
      ACC_LOAD:  perm_ok = sel_perm[0];
      ACC_STORE: perm_ok = sel_perm[1];
      ACC_FETCH: perm_ok = sel_perm[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (IMPL_ENTRIES == 0)         allow_o = 1'b1;
    else if (!hit)                 allow_o = is_m;
    else if (!sel_full)            allow_o = 1'b0;
    else if (is_m && !sel_locked)  allow_o = 1'b1;
    else                           allow_o = perm_ok;
  end

  assign fault_o = !allow_o;

  always_comb begin
    if (IMPL_ENTRIES > 0 && !(|ovl) && !is_m) begin
      a_r1_unmatched_low_priv: assert (fault_o)
        else $error("a_r1_unmatched_low_priv: unmatched S/U access not denied");
    end
    if (IMPL_ENTRIES == 0) begin
      a_r2_no_entries_open: assert (allow_o)
        else $error("a_r2_no_entries_open: access denied with no entries");
    end
    if (hit && !sel_full) begin
      a_r5_partial_denied: assert (fault_o)
        else $error("a_r5_partial_denied: partially covered access allowed");
    end
    if (is_m && !(|ovl)) begin
      a_r7_machine_unmatched: assert (allow_o)
        else $error("a_r7_machine_unmatched: unmatched machine access denied");
    end
    if (is_m && hit && sel_full && !sel_locked) begin
      a_r7_machine_unlocked: assert (allow_o)
        else $error("a_r7_machine_unlocked: unlocked entry restricted machine access");
    end
  end

endmodule

// File: tb/pmpc_checker_tb.sv
`timescale 1ns/1ps
module pmpc_checker_tb;

  localparam int N  = 16;
  localparam int PW = 34;
  localparam int AW = PW - 2;

  localparam logic [7:0] C_L = 8'h80, C_TOR = 8'h08, C_GAP = 8'h10, C_NAP = 8'h18;
  localparam logic [7:0] C_X = 8'h04, C_W = 8'h02, C_R = 8'h01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [8*N-1:0]  cfg_m = '0, cfg_g = '0, cfg_n = '0;
  logic [AW*N-1:0] adr_m = '0, adr_g = '0, adr_n = '0;
  logic [PW-1:0]   req_addr = '0;
  logic [1:0]      req_size = '0, req_kind = '0, req_priv = '0;
  logic allow_m, fault_m, allow_g, fault_g, allow_n, fault_n;

  pmpc_checker #(.NUM_ENTRIES(N), .IMPL_ENTRIES(8), .PADDR_W(PW), .GRAIN(0)) u_dut (
    .cfg_flat_i(cfg_m), .addr_flat_i(adr_m), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_kind_i(req_kind), .req_priv_i(req_priv),
    .allow_o(allow_m), .fault_o(fault_m));

  pmpc_checker #(.NUM_ENTRIES(N), .IMPL_ENTRIES(8), .PADDR_W(PW), .GRAIN(2)) u_dut_grain (
    .cfg_flat_i(cfg_g), .addr_flat_i(adr_g), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_kind_i(req_kind), .req_priv_i(req_priv),
    .allow_o(allow_g), .fault_o(fault_g));

  pmpc_checker #(.NUM_ENTRIES(N), .IMPL_ENTRIES(0), .PADDR_W(PW), .GRAIN(0)) u_dut_none (
    .cfg_flat_i(cfg_n), .addr_flat_i(adr_n), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_kind_i(req_kind), .req_priv_i(req_priv),
    .allow_o(allow_n), .fault_o(fault_n));

  typedef struct {
    int    dut;
    bit    exp;
    string req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit reported = 1'b0;

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic set_entry(input int d, input int idx, input logic [7:0] c, input logic [AW-1:0] a);
    @(posedge clk); #1;
    case (d)
      0: begin cfg_m[idx*8 +: 8] = c; adr_m[idx*AW +: AW] = a; end
      1: begin cfg_g[idx*8 +: 8] = c; adr_g[idx*AW +: AW] = a; end
      default: begin cfg_n[idx*8 +: 8] = c; adr_n[idx*AW +: AW] = a; end
    endcase
  endtask

  // driver: apply one request and queue its expected verdict
  task automatic chk(input int d, input logic [PW-1:0] a, input logic [1:0] sz,
                     input logic [1:0] k, input logic [1:0] p, input bit e, input string r);
    sb_item_t it;
    @(posedge clk); #1;
    req_addr = a; req_size = sz; req_kind = k; req_priv = p;
    it.dut = d; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  // monitor: compare on the falling edge, after inputs have settled
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      sb_item_t it;
      logic got;
      it = sb_q.pop_front();
      got = (it.dut == 0) ? allow_m : (it.dut == 1) ? allow_g : allow_n;
      checks++;
      if (got !== it.exp || ((it.dut == 0) && (fault_m !== !it.exp))) begin
        failures++;
        $display("FAIL %s dut=%0d addr=%h size=%0d kind=%0d priv=%0d actual=%b expected=%b",
                 it.req, it.dut, req_addr, req_size, req_kind, req_priv, got, it.exp);
      end
    end
  end

  localparam logic [1:0] U = 2'd0, S = 2'd1, M = 2'd3;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2, RS = 2'd3;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // reset state: all configuration cleared
    chk(0, 34'h0, 2'd2, LD, S, 1'b0, "R1");
    chk(0, 34'h0, 2'd2, LD, M, 1'b1, "R7");
    chk(2, 34'h0, 2'd2, LD, U, 1'b1, "R2");

    // main instance layout
    set_entry(0, 0, C_TOR | C_R, 32'h100);               // [0x0, 0x400)
    set_entry(0, 1, C_L | C_NAP | C_W | C_R, 32'h41F);   // [0x1000, 0x1100)
    set_entry(0, 2, C_TOR | C_X, 32'h800);               // [0x107C, 0x2000)
    set_entry(0, 3, C_L | C_NAP | C_R, 32'h2FFF);        // [0x8000, 0x10000)
    set_entry(0, 4, C_GAP | C_X | C_W | C_R, 32'h6000);  // mode 2: never matches
    set_entry(0, 8, C_NAP | C_X | C_W | C_R, 32'h401F);  // hardwired entry

    chk(0, 34'h10,  2'd2, LD, S, 1'b1, "R3");
    chk(0, 34'h10,  2'd2, ST, U, 1'b0, "R6");
    chk(0, 34'h3FC, 2'd2, FE, S, 1'b0, "R6");
    chk(0, 34'h3FC, 2'd2, LD, S, 1'b1, "R3");
    chk(0, 34'h400, 2'd0, LD, S, 1'b0, "R1");
    chk(0, 34'h3FC, 2'd3, LD, S, 1'b0, "R5");
    chk(0, 34'h1080, 2'd3, ST, S, 1'b1, "R8");
    chk(0, 34'h1080, 2'd2, FE, S, 1'b0, "R4");
    chk(0, 34'h1200, 2'd2, FE, S, 1'b1, "R3");
    chk(0, 34'h10FC, 2'd2, LD, S, 1'b1, "R8");
    chk(0, 34'h10FC, 2'd3, LD, S, 1'b0, "R5");
    chk(0, 34'h1100, 2'd2, FE, U, 1'b1, "R4");
    chk(0, 34'h10,   2'd2, ST, M, 1'b1, "R7");
    chk(0, 34'h8000, 2'd2, ST, M, 1'b0, "R7");
    chk(0, 34'h8000, 2'd2, LD, M, 1'b1, "R7");
    chk(0, 34'h20000, 2'd2, LD, M, 1'b1, "R7");
    chk(0, 34'h3FC,  2'd3, LD, M, 1'b0, "R5");
    chk(0, 34'h18000, 2'd2, LD, S, 1'b0, "R8");
    chk(0, 34'h10000, 2'd2, LD, S, 1'b0, "R9");
    chk(0, 34'h10,   2'd2, RS, S, 1'b0, "R6");

    // instance with no entries ignores its configuration
    set_entry(2, 0, C_TOR | C_R, 32'h100);
    chk(2, 34'h10, 2'd2, ST, S, 1'b1, "R2");
    chk(2, 34'h5000, 2'd1, FE, U, 1'b1, "R2");

    // coarse grain instance (G = 2, 16-byte regions)
    set_entry(1, 0, C_TOR | C_R, 32'h103);               // bound rounds to 0x400
    set_entry(1, 1, C_NAP | C_R, 32'h400);               // reads 0x401: [0x1000, 0x1010)
    chk(1, 34'h400,  2'd2, LD, S, 1'b0, "R10");
    chk(1, 34'h3FC,  2'd2, LD, S, 1'b1, "R10");
    chk(1, 34'h1008, 2'd2, LD, S, 1'b1, "R10");
    chk(1, 34'h100C, 2'd2, LD, S, 1'b1, "R10");
    chk(1, 34'h1010, 2'd2, LD, S, 1'b0, "R10");

    repeat (3) @(posedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard %0d items left actual=%0d expected=0", sb_q.size(), sb_q.size());
    end
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

endmodule